// File: doc/BRIEF.md
# Two-Wire Serial EEPROM Bus Slave

This block is the bus side of a small serial EEPROM. It oversamples the two bus lines with a fast system clock and cleans them up. It finds start and stop conditions and decodes the address byte against a fixed device code and strap pins. For each byte that the addressed device must accept, it pulls the data line low on the ninth clock. Its data line output is an open-drain enable: when the enable is high, the pad is pulled low.

In a write transfer, the first byte after the address byte loads a word pointer. Each later byte goes out on a one-cycle strobe, with its address, to a separate page buffer. When a stop arrives, a single commit pulse tells that buffer to program what it holds. In a read transfer, bytes are served from a register array, most significant bit first. The pointer steps forward after every byte and wraps from the top of the array to zero. The page buffer fills the array through a plain write port.

The parameter `ADDR_W` selects the density. At 7 or 8 bits, all three straps are compared. At 9 bits, bit 1 of the address byte is a page select. It becomes the top bit of the word pointer, and only two straps are compared.

Top module: `ee_serial_slave`

## Requirements
- R1: After reset, the data line enable is low, no write strobe or commit pulse is given, and the block waits for a start.
- R2: A start is the data line falling while the clock line is high, and a stop is the data line rising while the clock line is high. Until a start is seen, clocked bytes get no acknowledge.
- R3: The address byte is sent MSB first. Bits [7:4] must be 1010, bit 3 must equal strap[2], and bit 2 must equal strap[1]. On a mismatch, the device does not acknowledge and ignores all further bytes until the next start.
- R4: When ADDR_W is 7 or 8, address bit 1 must equal strap[0]. When ADDR_W is 9, address bit 1 is not compared; it is loaded into pointer bit 8 at every matching address byte, whether for read or write.
- R5: The device drives the data line low through the ninth clock after a matching address byte, and after every word-address and data byte of a write.
- R6: Address bit 0 set to 0 selects write. The next byte loads the low pointer bits. Each later byte pulses wr_strobe_o for one cycle, with wr_addr_o set to the pointer and wr_data_o set to the byte, and the pointer then increments.
- R7: commit_o pulses for one cycle on a stop, but only when at least one data byte was received since the last commit. A read-only transfer gives no commit.
- R8: Address bit 0 set to 1 selects read. The byte at the pointer is sent MSB first, and the enable changes only after a falling clock edge. The pointer increments after each byte, so consecutive bytes come out in order. A word written through the array port before a byte is loaded is the value sent.
- R9: A master NACK (data line high on the ninth clock of a read byte) ends the read, and the data line stays released.
- R10: The pointer wraps from the last array address to zero.
- R11: A start seen during a transfer restarts address reception and keeps the pointer, so a write of the word address followed by a repeated start and a read gives a random read.
- R12: Each line passes through a two-flop synchronizer and a three-sample majority vote, so a pulse one system clock wide is rejected and causes no false start or stop.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than the bus clock |
| rst_n | input | 1 | Synchronous active-low reset |
| scl_i | input | 1 | Bus clock line as seen at the pad |
| sda_i | input | 1 | Bus data line as seen at the pad |
| strap_i | input | 3 | Device select straps {A2, A1, A0} |
| sda_oe_o | output | 1 | Pull data line low when high |
| wr_strobe_o | output | 1 | One-cycle pulse per received write data byte |
| wr_addr_o | output | ADDR_W | Word address of the handed-off byte |
| wr_data_o | output | 8 | Handed-off data byte |
| commit_o | output | 1 | One-cycle pulse after a stop that ends a write with data |
| mem_we_i | input | 1 | Array write enable from the page buffer |
| mem_waddr_i | input | ADDR_W | Array write address |
| mem_wdata_i | input | 8 | Array write data |

## Verification
The array's external write port and the controller's load of the next read byte from that array can fall in the same system cycle. The bench provokes this by keeping the write port busy on the address the pointer will reach, across the whole master-acknowledge clock of a sequential read. A write therefore lands on the very cycle of the load. The byte sent is judged against the new value, never the stale one. A second overlap is a single-cycle glitch on the data line while the clock line is high, which would otherwise look like a start and a stop together. It is judged by the data byte still being handed off at the expected address.

// File: rtl/ee_pkg.sv
// Shared constants and the controller state type for the serial EEPROM slave.
package ee_pkg;
    localparam logic [3:0] DEV_CODE = 4'b1010;
    localparam int         BYTE_W   = 8;

    typedef enum logic [3:0] {
        S_IDLE,       // waiting for a start
        S_DEV,        // receiving the address byte
        S_DEV_ACK,    // acknowledging the address byte
        S_WORD,       // receiving the word address
        S_WORD_ACK,   // acknowledging the word address
        S_WDATA,      // receiving write data
        S_WDATA_ACK,  // acknowledging write data
        S_RDATA,      // sending a read byte
        S_RACK        // sampling the master acknowledge
    } ctrl_state_t;
endpackage

// File: rtl/ee_line_filter.sv
// Cleans one bus line: a synchronizer chain, then a majority vote over the
// last VOTE samples. Assumes VOTE is odd. The output resets to the idle-high level.
module ee_line_filter #(
    parameter int SYNC_W = 2,
    parameter int VOTE   = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic raw_i,
    output logic filt_o
);
    localparam int CNT_W = $clog2(VOTE + 1);

    logic [SYNC_W-1:0] sync_q;
    logic [VOTE-1:0]   hist_q;
    logic [CNT_W-1:0]  votes;

    // Synchronize the pad level and keep the recent sample history.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sync_q <= '1;
            hist_q <= '1;
        end else begin
            sync_q <= {sync_q[SYNC_W-2:0], raw_i};
            hist_q <= {hist_q[VOTE-2:0], sync_q[SYNC_W-1]};
        end
    end

    // Count the high samples in the history window.
    always_comb begin
        votes = '0;
        for (int k = 0; k < VOTE; k++) votes = votes + CNT_W'(hist_q[k]);
    end

    // Register the majority decision.
    always_ff @(posedge clk) begin
        if (!rst_n) filt_o <= 1'b1;
        else        filt_o <= (votes > CNT_W'(VOTE / 2));
    end
endmodule

// File: rtl/ee_bus_cond.sv
// Finds clock edges and start/stop conditions on the filtered lines.
// Assumes both inputs come from filters of equal latency.
module ee_bus_cond (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_f,
    input  logic sda_f,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_det,
    output logic stop_det
);
    logic scl_q, sda_q;

    // Hold the previous filtered levels.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            scl_q <= 1'b1;
            sda_q <= 1'b1;
        end else begin
            scl_q <= scl_f;
            sda_q <= sda_f;
        end
    end

    // Decode edges; a condition needs the clock high on both samples.
    always_comb begin
        scl_rise  = scl_f & ~scl_q;
        scl_fall  = ~scl_f & scl_q;
        start_det = scl_f & scl_q & sda_q & ~sda_f;
        stop_det  = scl_f & scl_q & ~sda_q & sda_f;
    end
endmodule

// File: rtl/ee_mem_array.sv
// Register-based byte array: one synchronous write port, one combinational
// read port. A read in a write cycle returns the old contents.
module ee_mem_array #(
    parameter int AW = 9,
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [DW-1:0] wdata,
    input  logic [AW-1:0] raddr,
    output logic [DW-1:0] rdata
);
    localparam int DEPTH = 1 << AW;

    logic [DW-1:0] cells [DEPTH];

    // Store a byte from the page buffer.
    always_ff @(posedge clk) begin
        if (we) cells[waddr] <= wdata;
    end

    // Present the byte at the pointer.
    assign rdata = cells[raddr];
endmodule

// File: rtl/ee_slave_ctrl.sv
// Byte-level protocol controller: address match, acknowledge, word pointer,
// write handoff and read streaming. Assumes single-cycle edge and condition pulses.
module ee_slave_ctrl
    import ee_pkg::*;
#(
    parameter int AW = 9
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          sda_f,
    input  logic          scl_rise,
    input  logic          scl_fall,
    input  logic          start_det,
    input  logic          stop_det,
    input  logic [2:0]    strap,
    input  logic [7:0]    rdata,
    output logic [AW-1:0] ptr,
    output logic          sda_oe,
    output logic          wr_strobe,
    output logic [AW-1:0] wr_addr,
    output logic [7:0]    wr_data,
    output logic          commit
);
    localparam bit HAS_PS = (AW > 8);
    localparam int LOW_W  = HAS_PS ? 8 : AW;

    ctrl_state_t state;
    logic [3:0]  cnt;
    logic [7:0]  sr, tx;
    logic        rw, mack, pending;
    logic        addr_ok;

    // Compare a complete address byte against the device code and straps.
    always_comb begin
        addr_ok = (sr[7:4] == DEV_CODE) && (sr[3] == strap[2]) && (sr[2] == strap[1])
                  && (HAS_PS || (sr[1] == strap[0]));
    end

    // Sequence the transfer one bus clock at a time.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= S_IDLE; cnt <= '0; sr <= '0; tx <= '0;
            rw <= 1'b0; mack <= 1'b0; pending <= 1'b0; ptr <= '0;
            sda_oe <= 1'b0; wr_strobe <= 1'b0; wr_addr <= '0; wr_data <= '0; commit <= 1'b0;
        end else begin
            wr_strobe <= 1'b0;
            commit    <= 1'b0;
            if (start_det) begin
                state <= S_DEV; cnt <= '0; sda_oe <= 1'b0;
            end else if (stop_det) begin
                state <= S_IDLE; sda_oe <= 1'b0; commit <= pending; pending <= 1'b0;
            end else begin
                case (state)
                    S_DEV, S_WORD, S_WDATA: begin
                        if (scl_rise && cnt < 4'd8) begin
                            sr  <= {sr[6:0], sda_f};
                            cnt <= cnt + 4'd1;
                        end else if (scl_fall && cnt == 4'd8) begin
                            cnt <= '0;
                            if (state == S_DEV) begin
                                if (addr_ok) begin
                                    if (HAS_PS) ptr[AW-1] <= sr[1];
                                    rw <= sr[0]; sda_oe <= 1'b1; state <= S_DEV_ACK;
                                end else begin
                                    state <= S_IDLE;
                                end
                            end else if (state == S_WORD) begin
                                ptr[LOW_W-1:0] <= sr[LOW_W-1:0];
                                sda_oe <= 1'b1; state <= S_WORD_ACK;
                            end else begin
                                wr_strobe <= 1'b1; wr_addr <= ptr; wr_data <= sr;
                                ptr <= ptr + AW'(1); pending <= 1'b1;
                                sda_oe <= 1'b1; state <= S_WDATA_ACK;
                            end
                        end
                    end
                    S_DEV_ACK: if (scl_fall) begin
                        cnt <= '0;
                        if (rw) begin
                            tx <= rdata; sda_oe <= ~rdata[7]; state <= S_RDATA;
                        end else begin
                            sda_oe <= 1'b0; state <= S_WORD;
                        end
                    end
                    S_WORD_ACK, S_WDATA_ACK: if (scl_fall) begin
                        sda_oe <= 1'b0; cnt <= '0; state <= S_WDATA;
                    end
                    S_RDATA: if (scl_fall) begin
                        if (cnt == 4'd7) begin
                            sda_oe <= 1'b0; ptr <= ptr + AW'(1); state <= S_RACK;
                        end else begin
                            tx <= {tx[6:0], 1'b0}; sda_oe <= ~tx[6]; cnt <= cnt + 4'd1;
                        end
                    end
                    S_RACK: begin
                        if (scl_rise) mack <= ~sda_f;
                        if (scl_fall) begin
                            if (mack) begin
                                tx <= rdata; sda_oe <= ~rdata[7]; cnt <= '0; state <= S_RDATA;
                            end else begin
                                state <= S_IDLE;
                            end
                        end
                    end
                    default: ;
                endcase
            end
        end
    end

    AST_IDLE_RELEASED: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_IDLE) |-> !sda_oe); // R9
    AST_OE_AFTER_FALL: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(sda_oe) |-> $past(scl_fall || start_det || stop_det)); // R8
    AST_COMMIT_ON_STOP: assert property (@(posedge clk) disable iff (!rst_n)
        commit |-> $past(stop_det)); // R7
    AST_STROBE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        wr_strobe |=> !wr_strobe); // R6
    AST_START_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
        start_det |=> (state == S_DEV && !sda_oe)); // R11
endmodule

// File: rtl/ee_serial_slave.sv
// Top of the serial EEPROM bus slave: line filters, condition detector,
// protocol controller and read array. ADDR_W must be 7, 8 or 9.
module ee_serial_slave #(
    parameter int ADDR_W = 9
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scl_i,
    input  logic              sda_i,
    input  logic [2:0]        strap_i,
    output logic              sda_oe_o,
    output logic              wr_strobe_o,
    output logic [ADDR_W-1:0] wr_addr_o,
    output logic [7:0]        wr_data_o,
    output logic              commit_o,
    input  logic              mem_we_i,
    input  logic [ADDR_W-1:0] mem_waddr_i,
    input  logic [7:0]        mem_wdata_i
);
    localparam int LINES = 2;

    logic [LINES-1:0] raw_bus, filt_bus;
    logic scl_rise, scl_fall, start_det, stop_det;
    logic [ADDR_W-1:0] ptr;
    logic [7:0] rdata;

    assign raw_bus = {scl_i, sda_i};

    // One filter per bus line: index 1 is the clock, index 0 the data.
    for (genvar g = 0; g < LINES; g++) begin : g_filt
        ee_line_filter #(.SYNC_W(2), .VOTE(3)) u_filt (
            .clk(clk), .rst_n(rst_n), .raw_i(raw_bus[g]), .filt_o(filt_bus[g])
        );
    end

    ee_bus_cond u_cond (
        .clk(clk), .rst_n(rst_n), .scl_f(filt_bus[1]), .sda_f(filt_bus[0]),
        .scl_rise(scl_rise), .scl_fall(scl_fall), .start_det(start_det), .stop_det(stop_det)
    );

    ee_mem_array #(.AW(ADDR_W), .DW(8)) u_mem (
        .clk(clk), .we(mem_we_i), .waddr(mem_waddr_i), .wdata(mem_wdata_i),
        .raddr(ptr), .rdata(rdata)
    );

    ee_slave_ctrl #(.AW(ADDR_W)) u_ctrl (
        .clk(clk), .rst_n(rst_n), .sda_f(filt_bus[0]),
        .scl_rise(scl_rise), .scl_fall(scl_fall), .start_det(start_det), .stop_det(stop_det),
        .strap(strap_i), .rdata(rdata), .ptr(ptr), .sda_oe(sda_oe_o),
        .wr_strobe(wr_strobe_o), .wr_addr(wr_addr_o), .wr_data(wr_data_o), .commit(commit_o)
    );
endmodule

// File: tb/tb_ee_serial_slave.sv
// Directed bench: a 9-bit device (dut) and a 7-bit device (dut_small) share one wired bus.
module tb_ee_serial_slave;
    localparam int H = 16;
    localparam int Q = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic scl = 1'b1, sda_m = 1'b1;
    logic oe_big, oe_small, sda_line;

    logic       big_wr, big_cm, big_we = 1'b0;
    logic [8:0] big_wa_o, big_wa = '0;
    logic [7:0] big_wd_o, big_wd = '0;
    logic       sm_wr, sm_cm, sm_we = 1'b0;
    logic [6:0] sm_wa_o, sm_wa = '0;
    logic [7:0] sm_wd_o, sm_wd = '0;

    logic [7:0] big_m [512];
    logic [7:0] sm_m [128];

    int n_chk = 0, n_bad = 0;
    int big_nwr = 0, big_ncm = 0, sm_nwr = 0, sm_ncm = 0;
    logic [8:0] big_la; logic [7:0] big_ld;
    logic [6:0] sm_la;  logic [7:0] sm_ld;
    bit done = 0;

    always #2 clk = ~clk;
    assign sda_line = sda_m & ~oe_big & ~oe_small;

    ee_serial_slave #(.ADDR_W(9)) dut (
        .clk(clk), .rst_n(rst_n), .scl_i(scl), .sda_i(sda_line), .strap_i(3'b110),
        .sda_oe_o(oe_big), .wr_strobe_o(big_wr), .wr_addr_o(big_wa_o), .wr_data_o(big_wd_o),
        .commit_o(big_cm), .mem_we_i(big_we), .mem_waddr_i(big_wa), .mem_wdata_i(big_wd)
    );
    ee_serial_slave #(.ADDR_W(7)) dut_small (
        .clk(clk), .rst_n(rst_n), .scl_i(scl), .sda_i(sda_line), .strap_i(3'b011),
        .sda_oe_o(oe_small), .wr_strobe_o(sm_wr), .wr_addr_o(sm_wa_o), .wr_data_o(sm_wd_o),
        .commit_o(sm_cm), .mem_we_i(sm_we), .mem_waddr_i(sm_wa), .mem_wdata_i(sm_wd)
    );

    // Log handoff and commit pulses seen at the ports.
    always @(posedge clk) begin
        if (big_wr) begin big_nwr++; big_la = big_wa_o; big_ld = big_wd_o; end
        if (big_cm) big_ncm++;
        if (sm_wr)  begin sm_nwr++; sm_la = sm_wa_o; sm_ld = sm_wd_o; end
        if (sm_cm)  sm_ncm++;
    end

    function automatic logic [7:0] pat(input int a);
        return 8'(a * 37 + 11);
    endfunction

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic check(input string what, input logic [15:0] act, input logic [15:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", what, act, exp);
        end
    endtask

    task automatic bus_start();
        sda_m = 1'b1; tick(H); scl = 1'b1; tick(H); sda_m = 1'b0; tick(H); scl = 1'b0; tick(Q);
    endtask

    task automatic bus_stop();
        sda_m = 1'b0; tick(Q); scl = 1'b1; tick(H); sda_m = 1'b1; tick(H);
    endtask

    task automatic send_byte(input logic [7:0] b, input bit glitch, output bit acked);
        for (int i = 7; i >= 0; i--) begin
            sda_m = b[i]; tick(H); scl = 1'b1; tick(H / 2);
            if (glitch && i == 7) begin sda_m = 1'b0; tick(1); sda_m = 1'b1; tick(H / 2 - 1); end
            else tick(H / 2);
            scl = 1'b0; tick(Q);
        end
        sda_m = 1'b1; tick(H); scl = 1'b1; tick(H / 2);
        acked = (sda_line == 1'b0);
        tick(H / 2); scl = 1'b0; tick(Q);
    endtask

    task automatic read_byte(output logic [7:0] b, input bit mack);
        sda_m = 1'b1;
        for (int i = 7; i >= 0; i--) begin
            tick(H); scl = 1'b1; tick(H / 2); b[i] = sda_line; tick(H / 2); scl = 1'b0; tick(Q);
        end
        sda_m = mack ? 1'b0 : 1'b1; tick(H); scl = 1'b1; tick(H); scl = 1'b0; tick(Q);
        sda_m = 1'b1;
    endtask

    task automatic preload();
        for (int a = 0; a < 512; a++) begin
            big_we = 1'b1; big_wa = 9'(a); big_wd = pat(a); big_m[a] = pat(a); tick(1);
        end
        big_we = 1'b0;
        for (int a = 0; a < 128; a++) begin
            sm_we = 1'b1; sm_wa = 7'(a); sm_wd = pat(a) ^ 8'hFF; sm_m[a] = pat(a) ^ 8'hFF; tick(1);
        end
        sm_we = 1'b0;
    endtask

    task automatic t_reset();
        check("R1 line released", 16'(sda_line), 16'h1);
        check("R1 no strobe", 16'(big_nwr + sm_nwr), 16'h0);
        check("R1 no commit", 16'(big_ncm + sm_ncm), 16'h0);
    endtask

    task automatic t_no_start();
        bit ak;
        send_byte(8'hAC, 0, ak);
        check("R2 no ack before start", 16'(ak), 16'h0);
    endtask

    task automatic t_write();
        bit ak;
        bus_start();
        send_byte(8'hAC, 0, ak); check("R5 ack address", 16'(ak), 16'h1);
        send_byte(8'h10, 0, ak); check("R5 ack word", 16'(ak), 16'h1);
        send_byte(8'h11, 0, ak); check("R5 ack data", 16'(ak), 16'h1);
        check("R6 first addr", 16'(big_la), 16'h010);
        check("R6 first data", 16'(big_ld), 16'h11);
        send_byte(8'h22, 0, ak);
        check("R6 incremented addr", 16'(big_la), 16'h011);
        check("R6 strobe count", 16'(big_nwr), 16'd2);
        check("R7 no commit before stop", 16'(big_ncm), 16'd0);
        bus_stop(); tick(8);
        check("R7 commit after stop", 16'(big_ncm), 16'd1);
        check("R6 other device silent", 16'(sm_nwr), 16'd0);
    endtask

    task automatic t_page_read();
        bit ak; logic [7:0] b;
        bus_start();
        send_byte(8'hAE, 0, ak); check("R4 page select address acked", 16'(ak), 16'h1);
        send_byte(8'h05, 0, ak);
        bus_start();
        send_byte(8'hAF, 0, ak); check("R11 repeated start acked", 16'(ak), 16'h1);
        read_byte(b, 1); check("R4 upper page byte", 16'(b), 16'(big_m[9'h105]));
        read_byte(b, 1); check("R8 sequential byte", 16'(b), 16'(big_m[9'h106]));
        read_byte(b, 0); check("R8 third byte", 16'(b), 16'(big_m[9'h107]));
        tick(8); check("R9 released after nack", 16'(sda_line), 16'h1);
        bus_stop(); tick(8);
        check("R7 read gives no commit", 16'(big_ncm), 16'd1);
    endtask

    task automatic t_wrap();
        bit ak; logic [7:0] b;
        bus_start(); send_byte(8'hAE, 0, ak); send_byte(8'hFF, 0, ak);
        bus_start(); send_byte(8'hAF, 0, ak);
        read_byte(b, 1); check("R10 top byte", 16'(b), 16'(big_m[9'h1FF]));
        read_byte(b, 0); check("R10 wrapped to zero", 16'(b), 16'(big_m[0]));
        bus_stop();
    endtask

    task automatic t_mismatch();
        bit ak;
        bus_start();
        send_byte(8'hA4, 0, ak); check("R3 mismatch nack", 16'(ak), 16'h0);
        send_byte(8'hAC, 0, ak); check("R3 idle until start", 16'(ak), 16'h0);
        bus_stop();
        check("R3 no strobe on mismatch", 16'(big_nwr + sm_nwr), 16'd2);
    endtask

    task automatic t_small();
        bit ak; logic [7:0] b;
        bus_start();
        send_byte(8'hA6, 0, ak); check("R4 small strap match", 16'(ak), 16'h1);
        send_byte(8'h85, 0, ak);
        send_byte(8'h3C, 0, ak);
        check("R4 seven-bit addr", 16'(sm_la), 16'h05);
        check("R6 small data", 16'(sm_ld), 16'h3C);
        bus_stop(); tick(8);
        check("R7 small commit", 16'(sm_ncm), 16'd1);
        bus_start(); send_byte(8'hA6, 0, ak); send_byte(8'h7F, 0, ak);
        bus_start(); send_byte(8'hA7, 0, ak);
        read_byte(b, 1); check("R10 small top", 16'(b), 16'(sm_m[127]));
        read_byte(b, 0); check("R10 small wrap", 16'(b), 16'(sm_m[0]));
        bus_stop();
    endtask

    task automatic t_glitch();
        bit ak;
        bus_start();
        send_byte(8'hAC, 0, ak); send_byte(8'h20, 0, ak);
        send_byte(8'hF7, 1, ak);
        check("R12 glitch byte acked", 16'(ak), 16'h1);
        check("R12 glitch byte addr", 16'(big_la), 16'h020);
        check("R12 glitch byte data", 16'(big_ld), 16'hF7);
        bus_stop(); tick(8);
        check("R12 commit still once", 16'(big_ncm), 16'd2);
    endtask

    task automatic t_collide();
        bit ak; logic [7:0] b;
        bus_start(); send_byte(8'hAC, 0, ak); send_byte(8'h30, 0, ak);
        bus_start(); send_byte(8'hAD, 0, ak);
        big_we = 1'b1; big_wa = 9'h031; big_wd = 8'hE1; big_m[9'h031] = 8'hE1;
        read_byte(b, 1); check("R8 byte before write", 16'(b), 16'(big_m[9'h030]));
        read_byte(b, 0); check("R8 freshly written byte", 16'(b), 16'h00E1);
        big_we = 1'b0;
        bus_stop();
    endtask

    initial begin
        tick(4); rst_n = 1'b1; tick(4);
        t_reset();
        preload();
        t_no_start();
        t_write();
        t_page_read();
        t_wrap();
        t_mismatch();
        t_small();
        t_glitch();
        t_collide();
        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual running expected finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end
endmodule